// File: doc/BRIEF.md
# Flash Block and Chip Erase Controller

This block is the erase engine of a NOR-style flash array together with the small word array it acts on. A host drives single-cycle bus writes and reads. Five unlock writes followed by a final select write start either an erase of one block or an erase of the whole array. The erase is only launched if the programming-voltage input reports its high level when the final write lands. Otherwise the command is dropped silently and the block stays in read mode.

While an erase runs, the block is busy for a fixed number of cycles per word. It rewrites each word of the target region to all ones, answers every read with a status word, and ignores every write. When it finishes it returns to read mode by itself. If the voltage leaves the high level during the erase, the engine stops and latches a fault. The status word then stays on the read bus until a reset command is written.

The array loads a fixed seed pattern on reset, so that an erase can be seen at the read port.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A block erase starts on six consecutive writes, compared on the low address bits [10:0] and the low data byte. Write 1 is 0xAA at 0x555, write 2 is 0x55 at 0x2AA, write 3 is 0x80 at 0x555, write 4 is 0xAA at 0x555, write 5 is 0x55 at 0x2AA, and write 6 is 0x30 at any address. `busy` is high from the cycle after the sixth write.
- R2: A chip erase uses the same first five writes, followed by 0x10 at 0x555 as the sixth write. It erases every word of the array.
- R3: A block erase sets to all ones every word of the block named by address bits [4:3] of the sixth write, where the array index is address bits [4:0]. All other words keep their contents. After reset, word i holds ((i*0x1357) mod 2^16) XOR 0xA5C3.
- R4: A block erase keeps `busy` high for CYCLES_PER_WORD*WORDS_PER_BLOCK cycles, which is 24 by default. A chip erase keeps it high for that count times NUM_BLOCKS, which is 96. Afterwards reads return array data without any command.
- R5: If `vpp_lvl` is not 2'b10 (high) when the sixth write lands, the command is dropped. `busy` stays low and the array is unchanged. The encodings are 2'b00 for low and 2'b01 for normal-high.
- R6: A write that does not match the expected step returns the sequence to its start. The steps that follow it cannot complete the command; only a full six-write sequence can.
- R7: While busy, every write is ignored, including the reset command and complete new sequences. The running erase completes unchanged.
- R8: While busy, every read returns the status word. Bit 7 is 0, bit 3 is 1, and bit 2 is 1 for a chip erase and 0 for a block erase. Bit 6 is 0 on the first read after launch and inverts on each later read.
- R9: If `vpp_lvl` leaves the high level during an erase, `busy` falls and the engine stops. Reads then return status with bits 5 and 4 set and bit 7 clear, and writes other than the reset command are ignored. Writing 0xF0 at any address clears the fault and restores read mode. Words erased before the fault stay erased.
- R10: Outside an erase or a fault, reads return the array word at address bits [4:0] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; reloads the seed pattern |
| bus_we | input | 1 | One-cycle write strobe |
| bus_re | input | 1 | Read strobe; advances the status toggle while busy or faulted |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data; only the low byte is decoded |
| vpp_lvl | input | 2 | Programming-voltage level: 00 low, 01 normal-high, 10 high |
| bus_rdata | output | DATA_W | Array word in read mode, otherwise the status word |
| busy | output | 1 | High while an erase is running |

## Verification
The hardest situation to reach is a fault in the middle of an erase. It needs a valid launch, and then the voltage must drop on a known cycle so that the number of words already erased is predictable. The bench waits a fixed number of cycles after the sixth write, lowers the level for a single cycle, and works out from the per-word cycle count which words are already all ones. Bursts of writes during a busy period come a close second. The bench sends a reset command and a complete chip-erase sequence while a block erase runs, then checks that only the original block changed.

// File: rtl/flash_erase_pkg.sv
`timescale 1ns/1ps
package flash_erase_pkg;

  typedef enum logic [1:0] {
    ER_READ  = 2'd0,
    ER_BUSY  = 2'd1,
    ER_FAULT = 2'd2
  } er_state_e;

  localparam logic [1:0]  VPP_LOW   = 2'b00;
  localparam logic [1:0]  VPP_NORM  = 2'b01;
  localparam logic [1:0]  VPP_HIGH  = 2'b10;

  localparam logic [7:0]  CODE_BLOCK = 8'h30;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_RESET = 8'hF0;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;

  // Address expected at unlock step k (k = 0..4).
  function automatic logic [10:0] unlock_addr(input logic [2:0] k);
    return (k == 3'd1 || k == 3'd4) ? KEY_ADDR_B : KEY_ADDR_A;
  endfunction

  // Data byte expected at unlock step k (k = 0..4).
  function automatic logic [7:0] unlock_data(input logic [2:0] k);
    case (k)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      default:    return 8'h80;
    endcase
  endfunction

  // Busy length of one erase, in clock cycles.
  function automatic int unsigned erase_cycles(input int unsigned cpw,
                                               input int unsigned wpb,
                                               input int unsigned nb,
                                               input logic        chip);
    return chip ? cpw * wpb * nb : cpw * wpb;
  endfunction

  // Seed contents loaded into word i at reset.
  function automatic logic [31:0] seed_word(input int unsigned i);
    logic [31:0] p;
    p = i * 32'h0000_1357;
    return {16'h0000, p[15:0] ^ 16'hA5C3};
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IDX_W  = 5,
  parameter int WB_W   = 3,
  localparam int BLK_W = IDX_W - WB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              start_blk,
  output logic              start_chip,
  output logic [BLK_W-1:0]  blk_sel,
  output logic              rst_cmd
);

  logic [2:0]  step_q;
  logic [10:0] key_addr;
  logic        hit_unlock;
  logic        hit_blk;
  logic        hit_chip;

  assign key_addr = addr[10:0];

  always_comb begin
    hit_unlock = (step_q < 3'd5) &&
                 (key_addr == unlock_addr(step_q)) &&
                 (wbyte == unlock_data(step_q));
    hit_blk    = (step_q == 3'd5) && (wbyte == CODE_BLOCK);
    hit_chip   = (step_q == 3'd5) && (wbyte == CODE_CHIP) &&
                 (key_addr == KEY_ADDR_A);
  end

  assign start_blk  = en && we && hit_blk;
  assign start_chip = en && we && hit_chip;
  assign blk_sel    = addr[IDX_W-1:WB_W];
  assign rst_cmd    = we && (wbyte == CODE_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           step_q <= 3'd0;
    else if (!en)         step_q <= 3'd0;
    else if (we)          step_q <= hit_unlock ? step_q + 3'd1 : 3'd0;
  end

  // R6
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we) |=> $stable(step_q));

  // R6
  seq_wrong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we && !hit_unlock) |=> (step_q == 3'd0));

  // R2
  seq_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_blk, start_chip}));

endmodule

// File: rtl/flash_erase_engine.sv
`timescale 1ns/1ps
module flash_erase_engine
  import flash_erase_pkg::*;
#(
  parameter int NB    = 4,
  parameter int WPB   = 8,
  parameter int CPW   = 3,
  parameter int IDX_W = 5,
  parameter int WB_W  = 3,
  localparam int BLK_W = IDX_W - WB_W,
  localparam int CYC_W = (CPW > 1) ? $clog2(CPW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_blk,
  input  logic             start_chip,
  input  logic [BLK_W-1:0] blk_sel,
  input  logic             vpp_high,
  input  logic             rst_cmd,
  output er_state_e        state,
  output logic             chip_q,
  output logic             launch,
  output logic             word_we,
  output logic [IDX_W-1:0] word_idx,
  output logic             fault_evt
);

  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CPW - 1);

  er_state_e        state_q;
  logic [CYC_W-1:0] cyc_q;
  logic [IDX_W-1:0] widx_q;
  logic [IDX_W-1:0] end_q;
  logic [BLK_W-1:0] blk_q;
  logic             last_word;

  assign launch    = (state_q == ER_READ) && (start_blk || start_chip) && vpp_high;
  assign word_we   = (state_q == ER_BUSY) && vpp_high && (cyc_q == CYC_LAST);
  assign fault_evt = (state_q == ER_BUSY) && !vpp_high;
  assign last_word = word_we && (widx_q == end_q);
  assign word_idx  = widx_q;
  assign state     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ER_READ;
      cyc_q   <= '0;
      widx_q  <= '0;
      end_q   <= '0;
      blk_q   <= '0;
      chip_q  <= 1'b0;
    end else begin
      case (state_q)
        ER_READ: begin
          if (launch) begin
            state_q <= ER_BUSY;
            chip_q  <= start_chip;
            blk_q   <= blk_sel;
            cyc_q   <= '0;
            widx_q  <= start_chip ? '0 : {blk_sel, {WB_W{1'b0}}};
            end_q   <= start_chip ? '1 : {blk_sel, {WB_W{1'b1}}};
          end
        end
        ER_BUSY: begin
          if (fault_evt) begin
            state_q <= ER_FAULT;
          end else if (word_we) begin
            cyc_q <= '0;
            if (last_word) state_q <= ER_READ;
            else           widx_q  <= widx_q + 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ER_FAULT: begin
          if (rst_cmd) state_q <= ER_READ;
        end
        default: state_q <= ER_READ;
      endcase
    end
  end

  // Cycle counter used only by the busy-length check.
  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (launch)              run_q <= '0;
    else if (state_q == ER_BUSY)  run_q <= run_q + 32'd1;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |-> (run_q + 32'd1 == erase_cycles(CPW, WPB, NB, chip_q)));

  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ER_BUSY) && vpp_high && !last_word) |=> (state_q == ER_BUSY));

  // R5
  vpp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ER_READ) && (start_blk || start_chip) && !vpp_high)
      |=> (state_q == ER_READ));

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ER_FAULT) && !rst_cmd) |=> (state_q == ER_FAULT));

  // R3
  blk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && !chip_q) |-> (word_idx[IDX_W-1:WB_W] == blk_q));

endmodule

// File: rtl/flash_status.sv
`timescale 1ns/1ps
module flash_status
  import flash_erase_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  er_state_e         state,
  input  logic              chip_q,
  input  logic              re,
  input  logic              launch,
  input  logic              fault_evt,
  output logic [DATA_W-1:0] status
);

  logic toggle_q;
  logic fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         toggle_q <= 1'b0;
    else if (launch)                    toggle_q <= 1'b0;
    else if (re && state != ER_READ)    toggle_q <= ~toggle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fault_q <= 1'b0;
    else if (fault_evt)          fault_q <= 1'b1;
    else if (state == ER_READ)   fault_q <= 1'b0;
  end

  always_comb begin
    status    = '0;
    status[7] = (state == ER_READ);
    status[6] = toggle_q;
    status[5] = fault_q;
    status[4] = fault_q;
    status[3] = (state != ER_READ);
    status[2] = chip_q;
  end

  // R9
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ER_FAULT) |-> (status[5] && status[4]));

  // R8
  toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && state == ER_BUSY) |=> (status[6] != $past(status[6])));

endmodule

// File: rtl/flash_word_array.sv
`timescale 1ns/1ps
module flash_word_array
  import flash_erase_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_ones,
  input  logic [IDX_W-1:0]  widx,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [31:0] SEED = seed_word(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= SEED[DATA_W-1:0];
      else if (we_ones && widx == IDX_W'(g))       mem[g] <= '1;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/flash_erase_ctrl.sv
`timescale 1ns/1ps
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int CYCLES_PER_WORD = 3,
  parameter int DATA_W          = 16,
  parameter int ADDR_W          = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [1:0]        vpp_lvl,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy
);

  localparam int WB_W  = $clog2(WORDS_PER_BLOCK);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int IDX_W = WB_W + BLK_W;
  localparam int WORDS = NUM_BLOCKS * WORDS_PER_BLOCK;

  er_state_e         state;
  logic              chip_q;
  logic              launch;
  logic              word_we;
  logic [IDX_W-1:0]  word_idx;
  logic              fault_evt;
  logic              start_blk;
  logic              start_chip;
  logic [BLK_W-1:0]  blk_sel;
  logic              rst_cmd;
  logic              vpp_high;
  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] status;

  assign vpp_high = (vpp_lvl == VPP_HIGH);

  flash_cmd_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WB_W(WB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(state == ER_READ), .we(bus_we),
    .addr(bus_addr), .wbyte(bus_wdata[7:0]),
    .start_blk(start_blk), .start_chip(start_chip),
    .blk_sel(blk_sel), .rst_cmd(rst_cmd)
  );

  flash_erase_engine #(.NB(NUM_BLOCKS), .WPB(WORDS_PER_BLOCK),
                       .CPW(CYCLES_PER_WORD), .IDX_W(IDX_W), .WB_W(WB_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_blk(start_blk), .start_chip(start_chip),
    .blk_sel(blk_sel), .vpp_high(vpp_high), .rst_cmd(rst_cmd),
    .state(state), .chip_q(chip_q), .launch(launch), .word_we(word_we),
    .word_idx(word_idx), .fault_evt(fault_evt)
  );

  flash_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .state(state), .chip_q(chip_q), .re(bus_re),
    .launch(launch), .fault_evt(fault_evt), .status(status)
  );

  flash_word_array #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we_ones(word_we), .widx(word_idx),
    .ridx(bus_addr[IDX_W-1:0]), .rdata(arr_rd)
  );

  assign busy      = (state == ER_BUSY);
  assign bus_rdata = (state == ER_READ) ? arr_rd : status;

  // R8
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!bus_rdata[7] && bus_rdata[3]));

  // R1
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

endmodule

// File: tb/flash_erase_ctrl_bench.sv
`timescale 1ns/1ps
module flash_erase_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  vpp = 2'b10;
  logic [15:0] rdata;
  logic        busy;

  int vectors = 0;
  int fails   = 0;
  logic [15:0] exp_mem [32];

  always #2 clk = ~clk;

  flash_erase_ctrl u_flash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .vpp_lvl(vpp), .bus_rdata(rdata), .busy(busy)
  );

  function automatic logic [15:0] bench_seed(int i);
    int v;
    v = (i * 4951) % 65536;
    return 16'(v) ^ 16'hA5C3;
  endfunction

  function automatic int bench_cycles(bit chip);
    return chip ? 3 * 8 * 4 : 3 * 8;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vpp = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) exp_mem[i] = bench_seed(i);
  endtask

  task automatic unlock5();
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(11'h555, 16'h0080);
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
  endtask

  task automatic model_erase(input int first, input int count);
    for (int i = first; i < first + count; i++) exp_mem[i] = 16'hFFFF;
  endtask

  task automatic verify_array(input string tag);
    logic [15:0] d;
    for (int i = 0; i < 32; i++) begin
      bus_read(11'(i), d);
      check(tag, {16'h0, d}, {16'h0, exp_mem[i]});
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] prev;
    int n;
    void'($urandom(32'd20240613));
    do_reset();

    // R10: reset state and seed pattern in read mode
    check("R10 busy after reset", {31'h0, busy}, 32'h0);
    verify_array("R10 seed read");

    // R1 R3 R4: block erase of block 2 (6th write at index 19)
    unlock5();
    bus_write(11'd19, 16'h0030);
    check("R1 busy after sixth write", {31'h0, busy}, 32'h1);
    wait_idle(n);
    check("R4 block busy length", n, bench_cycles(1'b0));
    model_erase(16, 8);
    verify_array("R3 block erase result");

    // R2 R4: chip erase
    unlock5();
    bus_write(11'h555, 16'h0010);
    check("R2 chip busy", {31'h0, busy}, 32'h1);
    wait_idle(n);
    check("R4 chip busy length", n, bench_cycles(1'b1));
    model_erase(0, 32);
    verify_array("R2 chip erase result");

    // R5: level not high at completion
    do_reset();
    unlock5();
    vpp = 2'b01;
    bus_write(11'd9, 16'h0030);
    check("R5 normal level no busy", {31'h0, busy}, 32'h0);
    unlock5();
    vpp = 2'b00;
    bus_write(11'h555, 16'h0010);
    check("R5 low level no busy", {31'h0, busy}, 32'h0);
    vpp = 2'b10;
    repeat (2) @(negedge clk);
    check("R5 still idle", {31'h0, busy}, 32'h0);
    verify_array("R5 array unchanged");

    // R6: wrong write mid-sequence
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(11'h555, 16'h0080);
    bus_write(11'h123, 16'h0077);
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(11'd5, 16'h0030);
    check("R6 broken sequence no busy", {31'h0, busy}, 32'h0);
    unlock5();
    bus_write(11'd5, 16'h0030);
    check("R6 full sequence busy", {31'h0, busy}, 32'h1);
    wait_idle(n);
    model_erase(0, 8);

    // R7: writes during busy ignored (block 1)
    unlock5();
    bus_write(11'd8, 16'h0030);
    bus_write(11'h000, 16'h00F0);
    unlock5();
    bus_write(11'h555, 16'h0010);
    check("R7 still busy after writes", {31'h0, busy}, 32'h1);
    wait_idle(n);
    repeat (3) @(negedge clk);
    check("R7 no second erase", {31'h0, busy}, 32'h0);
    model_erase(8, 8);
    verify_array("R7 only block 1 erased");

    // R8: status during a block erase, then a chip erase
    do_reset();
    unlock5();
    bus_write(11'd30, 16'h0030);
    for (int k = 0; k < 4; k++) begin
      bus_read(11'd0, d);
      check("R8 bit7 clear", {31'h0, d[7]}, 32'h0);
      check("R8 bit3 set", {31'h0, d[3]}, 32'h1);
      check("R8 bit2 block", {31'h0, d[2]}, 32'h0);
      check("R8 toggle", {31'h0, d[6]}, (k % 2 == 1) ? 32'h1 : 32'h0);
    end
    wait_idle(n);
    model_erase(24, 8);
    do_reset();
    unlock5();
    bus_write(11'h555, 16'h0010);
    bus_read(11'd3, d);
    check("R8 bit2 chip", {31'h0, d[2]}, 32'h1);
    check("R8 first toggle zero", {31'h0, d[6]}, 32'h0);
    wait_idle(n);
    model_erase(0, 32);

    // R9: level drops for one cycle after 7 busy cycles -> 2 words erased
    do_reset();
    unlock5();
    bus_write(11'd26, 16'h0030);
    repeat (7) @(negedge clk);
    vpp = 2'b00;
    @(negedge clk);
    vpp = 2'b10;
    check("R9 busy falls on fault", {31'h0, busy}, 32'h0);
    bus_read(11'd0, d);
    prev = d;
    check("R9 error bits", {30'h0, d[5], d[4]}, 32'h3);
    check("R9 bit7 clear", {31'h0, d[7]}, 32'h0);
    bus_write(11'h555, 16'h00AA);
    bus_read(11'd1, d);
    check("R9 status held", {30'h0, d[5], d[4]}, 32'h3);
    check("R9 toggle moves", {31'h0, d[6]}, {31'h0, ~prev[6]});
    bus_write(11'h4, 16'h00F0);
    model_erase(24, 2);
    verify_array("R9 read mode after reset cmd");

    // Random: block erases with random level, random reads in read mode
    for (int it = 0; it < 10; it++) begin
      int blk;
      int pick;
      int lo;
      blk  = int'($urandom_range(3, 0));
      pick = int'($urandom_range(3, 0));
      lo   = int'($urandom_range(7, 0));
      if (it % 4 == 0) do_reset();
      unlock5();
      vpp = (pick == 0) ? 2'b01 : 2'b10;
      bus_write(11'(blk * 8 + lo) | 11'h400, 16'h0030);
      if (pick == 0) begin
        check("R5 random level drop", {31'h0, busy}, 32'h0);
      end else begin
        wait_idle(n);
        check("R4 random busy length", n, bench_cycles(1'b0));
        model_erase(blk * 8, 8);
      end
      vpp = 2'b10;
      for (int r = 0; r < 6; r++) begin
        int a;
        a = int'($urandom_range(31, 0));
        bus_read(11'(a), d);
        check("R10 random read", {16'h0, d}, {16'h0, exp_mem[a]});
      end
    end
    verify_array("R3 random final array");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule